// File: doc/BRIEF.md
# Video FIFO with Hysteresis Flags

This block is the elastic buffer between a video output formatter, which pushes packed words, and an image output port, which pulls them. It holds 32 words of 32 bits by default, which is 64 pixels of 16-bit 4:2:2 video. A build parameter selects one of two clocking variants. In the shared variant both sides run on the same clock. In the crossed variant the read side has its own unrelated clock, and the two pointers pass between the domains as Gray codes through two-flop synchronisers.

The block reports its fill level through four flags. The almost-full mark and the almost-empty mark are each chosen by a 2-bit code. A "filled" flag has hysteresis: it rises at the almost-full mark and falls only once the level has come down to the almost-empty mark. A sticky overflow flag records any write that arrives while the buffer is full. Such a write is dropped.

The read port is first-word fall-through: `rdData` shows the oldest stored word whenever the buffer holds data. A read strobe moves on to the next word.

Top module: `hfifo_top`

## Requirements
- R1: Words leave in the order they were written, and up to 2^ADDR_W words of DATA_W bits are held. While the buffer is not empty, `rdData` shows the oldest word, and `rdEn` sampled high on a read clock edge discards that word.
- R2: `almostFull` is high while the write-side level is at or above the mark chosen by `afSel`: code 0 gives 16, code 1 gives 24, code 2 gives 28, code 3 gives 32 (full). For other depths these marks scale to D/2, D-D/4, D-D/8 and D.
- R3: `almostEmpty` is high while the read-side level is at or below the mark chosen by `aeSel`: code 0 gives 16, code 1 gives 8, code 2 gives 4, code 3 gives 0 (empty). For other depths these marks scale to D/2, D/4, D/8 and 0.
- R4: `filled` goes high on the write clock edge after the write-side level reaches the almost-full mark.
- R5: `filled` goes low on the write clock edge after the write-side level is at or below the almost-empty mark while below the almost-full mark. At all other levels it keeps its value, and setting wins over clearing.
- R6: A write presented while the buffer is full is dropped. The stored words and their order are unchanged.
- R7: `overflow` goes high after a write clock edge on which `wrValid` was high while the buffer was full. It then stays high until a write clock edge with `ovfClr` high and no new overflowing write; if both occur on the same edge, setting wins.
- R8: `rdEn` while the buffer is empty is ignored: no word is consumed and the level does not move.
- R9: With SYNC_MODE=1, both sides see the exact level; a write changes `almostEmpty` on that same write edge. With SYNC_MODE=0, each side sees the other side's pointer through a Gray-coded two-flop synchroniser. Each side's level is therefore conservative: the write side over-counts and the read side under-counts. A write reaches `almostEmpty` only several clock edges later.
- R10: While `rstN` is low, and straight after it is released, the buffer is empty: `almostEmpty`=1, `almostFull`=0, `filled`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock; tie to wrClk when SYNC_MODE=1 |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| wrValid | input | 1 | Write request for wrData |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Consume the word shown on rdData |
| rdData | output | DATA_W | Oldest stored word (fall-through) |
| afSel | input | 2 | Almost-full mark code |
| aeSel | input | 2 | Almost-empty mark code |
| ovfClr | input | 1 | Clears the overflow flag (write clock) |
| almostFull | output | 1 | Write-side level at or above its mark |
| almostEmpty | output | 1 | Read-side level at or below its mark |
| filled | output | 1 | Hysteresis fill flag |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds two copies of the block, both with ADDR_W=5 and DATA_W=16. One has SYNC_MODE=1 and runs on a single clock. The other has SYNC_MODE=0 and has its read clock in a 10:14 ratio to the write clock. The 32-entry depth lets the bench visit every fill level from 0 to 32 and test all four codes of each mark at each level. The narrower data word keeps the words unique so that the data order can be checked. The crossed copy shows the synchroniser lag, and the shared copy shows exact same-edge flags.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } fifoStrobes_t;

  function automatic int unsigned fullMark(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'd0:    return depth / 2;
      2'd1:    return depth - depth / 4;
      2'd2:    return depth - depth / 8;
      default: return depth;
    endcase
  endfunction

  function automatic int unsigned emptyMark(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return depth / 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/hfifo_datapath.sv
module hfifo_datapath
  import hfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                rstN,
  input  fifoStrobes_t        strobes,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W:0]     wrPtr,
  output logic [ADDR_W:0]     rdPtr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage is written only on an accepted write
  always_ff @(posedge wrClk) begin
    if (strobes.wrEn) mem[wrPtr[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)             wrPtr <= '0;
    else if (strobes.wrEn) wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)             rdPtr <= '0;
    else if (strobes.rdEn) rdPtr <= rdPtr + 1'b1;
  end

  // fall-through read of the oldest word
  assign rdData = mem[rdPtr[ADDR_W-1:0]];

endmodule

// File: rtl/hfifo_ctrl.sv
module hfifo_ctrl
  import hfifo_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int SYNC_MODE = 0
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              rdEn,
  input  logic              ovfClr,
  input  logic [1:0]        afSel,
  input  logic [1:0]        aeSel,
  input  logic [ADDR_W:0]   wrPtr,
  input  logic [ADDR_W:0]   rdPtr,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W:0]   wrLevel,
  output logic [ADDR_W:0]   rdLevel,
  output logic              almostFull,
  output logic              almostEmpty,
  output logic              filled,
  output logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [PW-1:0] rdPtrInWr;
  logic [PW-1:0] wrPtrInRd;
  logic [PW-1:0] afLimit;
  logic [PW-1:0] aeLimit;
  logic          isFull;
  logic          isEmpty;
  logic          atLowMark;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  generate
    if (SYNC_MODE != 0) begin : g_shared
      assign rdPtrInWr = rdPtr;
      assign wrPtrInRd = wrPtr;
    end else begin : g_cross
      logic [PW-1:0] wrGray, wrGrayS1, wrGrayS2;
      logic [PW-1:0] rdGray, rdGrayS1, rdGrayS2;

      always_ff @(posedge wrClk or negedge rstN) begin
        if (!rstN) begin
          wrGray   <= '0;
          rdGrayS1 <= '0;
          rdGrayS2 <= '0;
        end else begin
          wrGray   <= wrPtr ^ (wrPtr >> 1);
          rdGrayS1 <= rdGray;
          rdGrayS2 <= rdGrayS1;
        end
      end

      always_ff @(posedge rdClk or negedge rstN) begin
        if (!rstN) begin
          rdGray   <= '0;
          wrGrayS1 <= '0;
          wrGrayS2 <= '0;
        end else begin
          rdGray   <= rdPtr ^ (rdPtr >> 1);
          wrGrayS1 <= wrGray;
          wrGrayS2 <= wrGrayS1;
        end
      end

      assign rdPtrInWr = gray2bin(rdGrayS2);
      assign wrPtrInRd = gray2bin(wrGrayS2);
    end
  endgenerate

  assign afLimit = PW'(fullMark(afSel, DEPTH));
  assign aeLimit = PW'(emptyMark(aeSel, DEPTH));

  // write side: stale read pointer makes the level an over-count
  assign wrLevel   = wrPtr - rdPtrInWr;
  assign isFull    = (wrLevel == PW'(DEPTH));
  assign almostFull = (wrLevel >= afLimit);
  assign atLowMark = (wrLevel <= aeLimit);

  // read side: stale write pointer makes the level an under-count
  assign rdLevel     = wrPtrInRd - rdPtr;
  assign isEmpty     = (rdLevel == '0);
  assign almostEmpty = (rdLevel <= aeLimit);

  assign strobes.wrEn = wrValid & ~isFull;
  assign strobes.rdEn = rdEn & ~isEmpty;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)           filled <= 1'b0;
    else if (almostFull) filled <= 1'b1;
    else if (atLowMark)  filled <= 1'b0;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)                  overflow <= 1'b0;
    else if (wrValid && isFull) overflow <= 1'b1;
    else if (ovfClr)            overflow <= 1'b0;
  end

endmodule

// File: rtl/hfifo_top.sv
module hfifo_top
  import hfifo_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int SYNC_MODE = 0
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [1:0]        afSel,
  input  logic [1:0]        aeSel,
  input  logic              ovfClr,
  output logic              almostFull,
  output logic              almostEmpty,
  output logic              filled,
  output logic              overflow
);
  fifoStrobes_t      strobes;
  logic [ADDR_W:0]   wrPtr;
  logic [ADDR_W:0]   rdPtr;
  logic [ADDR_W:0]   wrLevel;
  logic [ADDR_W:0]   rdLevel;

  hfifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_MODE(SYNC_MODE)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrValid(wrValid), .rdEn(rdEn), .ovfClr(ovfClr),
    .afSel(afSel), .aeSel(aeSel),
    .wrPtr(wrPtr), .rdPtr(rdPtr),
    .strobes(strobes), .wrLevel(wrLevel), .rdLevel(rdLevel),
    .almostFull(almostFull), .almostEmpty(almostEmpty),
    .filled(filled), .overflow(overflow)
  );

  hfifo_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobes(strobes), .wrData(wrData), .rdData(rdData),
    .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

endmodule

// File: rtl/hfifo_checker.sv
module hfifo_checker
  import hfifo_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic            wrClk,
  input logic            rdClk,
  input logic            rstN,
  input logic            wrValid,
  input logic            ovfClr,
  input logic [1:0]      afSel,
  input logic [1:0]      aeSel,
  input fifoStrobes_t    strobes,
  input logic [ADDR_W:0] wrLevel,
  input logic [ADDR_W:0] rdLevel,
  input logic            filled,
  input logic            overflow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [PW-1:0] afLim;
  logic [PW-1:0] aeLim;
  assign afLim = PW'(fullMark(afSel, DEPTH));
  assign aeLim = PW'(emptyMark(aeSel, DEPTH));

  a_r1_wr_level_bound: assert property (@(posedge wrClk) disable iff (!rstN)
    wrLevel <= PW'(DEPTH));

  a_r1_rd_level_bound: assert property (@(posedge rdClk) disable iff (!rstN)
    rdLevel <= PW'(DEPTH));

  a_r6_no_store_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrLevel == PW'(DEPTH)) |-> !strobes.wrEn);

  a_r8_no_read_when_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdLevel == '0) |-> !strobes.rdEn);

  a_r7_overflow_holds: assert property (@(posedge wrClk) disable iff (!rstN)
    (overflow && !ovfClr) |=> overflow);

  a_r7_overflow_cause: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(overflow) |-> $past(wrValid && (wrLevel == PW'(DEPTH))));

  a_r4_filled_rise: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(filled) |-> $past(wrLevel >= afLim));

  a_r5_filled_fall: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(filled) |-> $past((wrLevel <= aeLim) && (wrLevel < afLim)));

endmodule

bind hfifo_top hfifo_checker #(.ADDR_W(ADDR_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrValid(wrValid), .ovfClr(ovfClr),
  .afSel(afSel), .aeSel(aeSel),
  .strobes(strobes), .wrLevel(wrLevel), .rdLevel(rdLevel),
  .filled(filled), .overflow(overflow)
);

// File: tb/tb_hfifo_top.sv
module tb_hfifo_top;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DW    = 16;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 1'b0, rdClkFree = 1'b0, rstN = 1'b0, phase = 1'b0;
  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClkFree = ~rdClkFree;
  wire rdClkCur = phase ? wrClk : rdClkFree;

  logic wrValid = 1'b0, rdEn = 1'b0, ovfClr = 1'b0;
  logic [1:0] afSel = 2'd0, aeSel = 2'd0;
  logic [DW-1:0] wrData = '0;

  logic [DW-1:0] xData, sData;
  logic xAf, xAe, xFl, xOv, sAf, sAe, sFl, sOv;

  hfifo_top #(.DATA_W(DW), .ADDR_W(AW), .SYNC_MODE(0)) dut (
    .wrClk(wrClk), .rdClk(rdClkFree), .rstN(rstN),
    .wrValid(wrValid & ~phase), .wrData(wrData), .rdEn(rdEn & ~phase), .rdData(xData),
    .afSel(afSel), .aeSel(aeSel), .ovfClr(ovfClr & ~phase),
    .almostFull(xAf), .almostEmpty(xAe), .filled(xFl), .overflow(xOv)
  );

  hfifo_top #(.DATA_W(DW), .ADDR_W(AW), .SYNC_MODE(1)) dutSync (
    .wrClk(wrClk), .rdClk(wrClk), .rstN(rstN),
    .wrValid(wrValid & phase), .wrData(wrData), .rdEn(rdEn & phase), .rdData(sData),
    .afSel(afSel), .aeSel(aeSel), .ovfClr(ovfClr & phase),
    .almostFull(sAf), .almostEmpty(sAe), .filled(sFl), .overflow(sOv)
  );

  wire [DW-1:0] rdData  = phase ? sData : xData;
  wire          aFull   = phase ? sAf : xAf;
  wire          aEmpty  = phase ? sAe : xAe;
  wire          fFlag   = phase ? sFl : xFl;
  wire          oFlag   = phase ? sOv : xOv;

  int checks = 0, failures = 0, cyc = 0, seqNo = 0;
  logic [DW-1:0] model[$];

  always @(posedge wrClk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s (mode %0d): got %0d expected %0d", req, what, phase, act, exp);
    end
  endtask

  function automatic int afMark(input int c);
    return (c == 3) ? DEPTH : DEPTH - (DEPTH >> (c + 1));
  endfunction
  function automatic int aeMark(input int c);
    return (c == 3) ? 0 : (DEPTH >> (c + 1));
  endfunction

  task automatic settle();
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClkCur);
    repeat (3) @(negedge wrClk);
  endtask

  task automatic pushWord();
    logic [DW-1:0] d;
    d = DW'(seqNo * 37 + 16'h5A00);
    seqNo++;
    @(negedge wrClk);
    wrValid = 1'b1;
    wrData  = d;
    @(negedge wrClk);
    wrValid = 1'b0;
    if (model.size() < DEPTH) model.push_back(d);
  endtask

  task automatic popWord(input string req);
    @(negedge rdClkCur);
    checkEq(req, "read data", int'(rdData), int'(model[0]));
    rdEn = 1'b1;
    @(negedge rdClkCur);
    rdEn = 1'b0;
    void'(model.pop_front());
  endtask

  task automatic doReset();
    rstN = 1'b0; wrValid = 1'b0; rdEn = 1'b0; ovfClr = 1'b0;
    model.delete();
    repeat (3) @(negedge wrClk);
    checkEq("R10", "almostEmpty in reset", int'(aEmpty), 1);
    checkEq("R10", "overflow in reset", int'(oFlag), 0);
    rstN = 1'b1;
    settle();
  endtask

  task automatic runPhase();
    // R10 reset state
    afSel = 2'd0; aeSel = 2'd0;
    doReset();
    checkEq("R10", "almostEmpty after reset", int'(aEmpty), 1);
    checkEq("R10", "almostFull after reset", int'(aFull), 0);
    checkEq("R10", "filled after reset", int'(fFlag), 0);
    checkEq("R10", "overflow after reset", int'(oFlag), 0);

    // R2/R3 sweep of every level against every code
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      if (lvl > 0) pushWord();
      settle();
      for (int c = 0; c < 4; c++) begin
        afSel = 2'(c); aeSel = 2'(c);
        @(negedge wrClk);
        @(negedge rdClkCur);
        checkEq("R2", $sformatf("almostFull lvl %0d code %0d", lvl, c), int'(aFull), int'(lvl >= afMark(c)));
        checkEq("R3", $sformatf("almostEmpty lvl %0d code %0d", lvl, c), int'(aEmpty), int'(lvl <= aeMark(c)));
      end
    end
    for (int k = 0; k < DEPTH; k++) popWord("R1");

    // R4/R5 hysteresis with marks 24 and 8
    afSel = 2'd1; aeSel = 2'd1;
    doReset();
    for (int k = 0; k < 23; k++) pushWord();
    settle();
    checkEq("R4", "filled at 23", int'(fFlag), 0);
    pushWord(); settle();
    checkEq("R4", "filled at 24", int'(fFlag), 1);
    for (int k = 0; k < 8; k++) popWord("R1");
    settle();
    checkEq("R5", "filled holds at 16", int'(fFlag), 1);
    for (int k = 0; k < 7; k++) popWord("R1");
    settle();
    checkEq("R5", "filled holds at 9", int'(fFlag), 1);
    popWord("R1"); settle();
    checkEq("R5", "filled clears at 8", int'(fFlag), 0);
    for (int k = 0; k < 15; k++) pushWord();
    settle();
    checkEq("R5", "filled stays low at 23", int'(fFlag), 0);
    pushWord(); settle();
    checkEq("R4", "filled sets again at 24", int'(fFlag), 1);

    // R5 equal marks (16/16): clears at 15
    afSel = 2'd0; aeSel = 2'd0;
    doReset();
    for (int k = 0; k < 16; k++) pushWord();
    settle();
    checkEq("R5", "filled set wins at equal marks", int'(fFlag), 1);
    popWord("R1"); settle();
    checkEq("R5", "filled clears at 15", int'(fFlag), 0);

    // R6/R7/R8 overflow and empty reads
    afSel = 2'd3; aeSel = 2'd3;
    doReset();
    for (int k = 0; k < DEPTH; k++) pushWord();
    settle();
    checkEq("R2", "almostFull at full", int'(aFull), 1);
    checkEq("R7", "overflow before extra write", int'(oFlag), 0);
    pushWord(); settle();
    checkEq("R7", "overflow after write to full", int'(oFlag), 1);
    for (int k = 0; k < DEPTH; k++) popWord("R6");
    settle();
    checkEq("R6", "empty after draining (extra word dropped)", int'(aEmpty), 1);
    checkEq("R7", "overflow sticky after drain", int'(oFlag), 1);
    @(negedge wrClk); ovfClr = 1'b1;
    @(negedge wrClk); ovfClr = 1'b0;
    @(negedge wrClk);
    checkEq("R7", "overflow cleared", int'(oFlag), 0);
    repeat (3) begin
      @(negedge rdClkCur); rdEn = 1'b1;
      @(negedge rdClkCur); rdEn = 1'b0;
    end
    settle();
    checkEq("R8", "still empty after empty reads", int'(aEmpty), 1);
    pushWord(); settle();
    checkEq("R8", "one word after empty reads", int'(aEmpty), 0);
    popWord("R8");

    // R9 visibility of a write on the read side
    doReset();
    @(negedge wrClk); wrValid = 1'b1; wrData = 16'h1234;
    @(negedge wrClk); wrValid = 1'b0; model.push_back(16'h1234);
    checkEq("R9", "almostEmpty one edge after write", int'(aEmpty), phase ? 0 : 1);
    settle();
    checkEq("R9", "almostEmpty after crossing", int'(aEmpty), 0);
    popWord("R9");
  endtask

  initial begin
    phase = 1'b0;
    runPhase();
    phase = 1'b1;
    runPhase();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule